// File: doc/BRIEF.md
# DS3 Frame Alignment Monitor

This block takes a received DS3 line as a serial stream, one bit per clock when the bit-enable strobe is high. It finds the M-frame boundary, keeps it, and reports an out-of-frame flag. While it is locked it also gives a pulse on the first bit of each M-frame, and it reports where the presented bit sits in the frame: the subframe, the block, and whether the bit is an overhead bit.

The M-frame is 4760 bits long and is made of 7 subframes. Each subframe holds 8 blocks, and each block is one overhead bit followed by 84 payload bits.

Acquisition has two stages. First the block locks onto the F-bits. Then it uses the M-bit pattern to find which subframe is which. The block can also be told to require one frame with correct P-bits before it declares in-frame.

Once the block is locked, three static inputs set the loss criteria:
- the number of F-bit errors, in a sliding window of 16, that declares out-of-frame;
- whether M-bit errors count toward out-of-frame;
- whether valid parity is needed before in-frame is declared again.

Top module: `ds3_frame_align`

## Requirements
- R1: After reset `oof_o` is 1 and `frame_start_o` is 0. The block begins its search from subframe 0, block 0, bit 0.
- R2: Block index b (0..7) carries the F-bits at b = 1, 3, 5 and 7, with the values 1, 0, 0, 1 on the overhead bit. While searching, each F-bit mismatch keeps the position counter where it is for that bit. This moves the candidate alignment one bit later. F-sync is declared after 10 correct F-bits in a row.
- R3: After F-sync, the overhead bits of block 0 are watched for the values 0, 1, 0 in subframe indices 4, 5 and 6. Seeing them fixes the subframe index, and only then can `oof_o` fall. An F-bit mismatch before lock sends the block back to the F-bit search.
- R4: With `f_tight_i` = 0, out-of-frame is declared when 6 of the last 16 F-bits are wrong.
- R5: With `f_tight_i` = 1, out-of-frame is declared when 3 of the last 16 F-bits are wrong.
- R6: With `m_oof_en_i` = 1, out-of-frame is declared when the M-bits are wrong in 3 of the last 4 M-frames. With `m_oof_en_i` = 0, M-bit errors never cause out-of-frame.
- R7: With `par_req_i` = 1, in-frame also needs a frame whose two P-bits both equal the XOR of all payload bits of the previous M-frame. The P-bits sit on the block-0 overhead bit of subframe indices 2 and 3. With `par_req_i` = 0, the P-bits have no effect on acquisition.
- R8: `sub_o` (0..6), `blk_o` (0..7) and `ovh_o` describe the bit presented in the current cycle. While in frame, `frame_start_o` pulses on the enabled first bit of every M-frame and on no other bit.
- R9: While `bit_en_i` is 0, neither the position nor the framing state changes, and `frame_start_o` stays 0.
- R10: The F-error and M-error histories are emptied when in-frame is declared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Received line bit |
| bit_en_i | input | 1 | High when `bit_i` holds a new bit |
| f_tight_i | input | 1 | F-error criterion: 0 = 6 of 16, 1 = 3 of 16 |
| m_oof_en_i | input | 1 | Allow M-bit errors to declare out-of-frame |
| par_req_i | input | 1 | Require correct P-bits before in-frame |
| oof_o | output | 1 | Out-of-frame status |
| frame_start_o | output | 1 | First bit of an M-frame while in frame |
| sub_o | output | 3 | Subframe index of the presented bit |
| blk_o | output | 3 | Block index of the presented bit |
| ovh_o | output | 1 | Presented bit is an overhead bit |

## Verification
The assertions assume that the three criterion inputs change only at points where they do not mix with a decision in progress. They also assume that every position update comes from an enabled bit, so a strobe held low must freeze the block.

The stimulus keeps to these assumptions:
- The generator always sends well-formed frames, with the two X-bits equal and P-bits computed from the payload it sent.
- Errors are injected only on chosen F-bits, M-bits or P-bits.
- The criterion inputs are changed only after a flush period.
- The start offset is a few bits before a subframe boundary, so the search converges within a short run.

// File: rtl/ds3fa_pkg.sv
package ds3fa_pkg;

  localparam int DS3_BLOCK_BITS = 85;
  localparam int DS3_BLOCKS     = 8;
  localparam int DS3_SUBS       = 7;

  typedef enum logic [1:0] {
    ST_FSRCH = 2'd0,
    ST_MSRCH = 2'd1,
    ST_PCHK  = 2'd2,
    ST_LOCK  = 2'd3
  } fa_state_t;

  // F-bits sit in odd blocks: 1 in the first and last of them, 0 between.
  function automatic logic f_expect(input int blk, input int nblocks);
    return (blk == 1) || (blk == nblocks - 1);
  endfunction

  // M-bits in the last three subframes read 0,1,0.
  function automatic logic m_expect(input int sub, input int nsubs);
    return sub == nsubs - 2;
  endfunction

endpackage

// File: rtl/ds3fa_pos_counter.sv
module ds3fa_pos_counter #(
  parameter int BLOCK_BITS = 85,
  parameter int BLOCKS     = 8,
  parameter int SUBS       = 7,
  localparam int BIT_W = $clog2(BLOCK_BITS),
  localparam int BLK_W = $clog2(BLOCKS),
  localparam int SUB_W = $clog2(SUBS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic             load_sub_i,
  input  logic [SUB_W-1:0] sub_val_i,
  output logic [BIT_W-1:0] bitc_o,
  output logic [BLK_W-1:0] blk_o,
  output logic [SUB_W-1:0] sub_o
);

  logic bit_wrap, blk_wrap;
  assign bit_wrap = bitc_o == BIT_W'(BLOCK_BITS - 1);
  assign blk_wrap = blk_o == BLK_W'(BLOCKS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitc_o <= '0;
      blk_o  <= '0;
      sub_o  <= '0;
    end else if (adv_i) begin
      if (bit_wrap) begin
        bitc_o <= '0;
        if (blk_wrap) begin
          blk_o <= '0;
          sub_o <= (sub_o == SUB_W'(SUBS - 1)) ? '0 : sub_o + 1'b1;
        end else begin
          blk_o <= blk_o + 1'b1;
        end
      end else begin
        bitc_o <= bitc_o + 1'b1;
      end
      if (load_sub_i) sub_o <= sub_val_i;
    end
  end

endmodule

// File: rtl/ds3fa_err_window.sv
module ds3fa_err_window #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic             err_i,
  output logic [CNT_W-1:0] cnt_if_o
);

  logic [DEPTH-1:0] hist_q;
  logic [DEPTH-1:0] cand;

  assign cand = {hist_q[DEPTH-2:0], err_i};

  // Error count of the window if the current candidate were shifted in.
  always_comb begin
    cnt_if_o = '0;
    for (int i = 0; i < DEPTH; i++) cnt_if_o = cnt_if_o + CNT_W'(cand[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hist_q <= '0;
    else if (clr_i)   hist_q <= '0;
    else if (shift_i) hist_q <= cand;
  end

  // R10
  win_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (hist_q == '0));

endmodule

// File: rtl/ds3fa_parity_acc.sv
module ds3fa_parity_acc (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic payload_i,
  input  logic frame0_i,
  input  logic bit_i,
  output logic prev_par_o
);

  logic acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= 1'b0;
      prev_par_o <= 1'b0;
    end else if (en_i) begin
      if (frame0_i) begin
        prev_par_o <= acc_q;
        acc_q      <= 1'b0;
      end else if (payload_i) begin
        acc_q <= acc_q ^ bit_i;
      end
    end
  end

endmodule

// File: rtl/ds3_frame_align.sv
module ds3_frame_align
  import ds3fa_pkg::*;
#(
  parameter int BLOCK_BITS  = DS3_BLOCK_BITS,
  parameter int BLOCKS      = DS3_BLOCKS,
  parameter int SUBS        = DS3_SUBS,
  parameter int FSYNC_LEN   = 10,
  parameter int F_WIN       = 16,
  parameter int F_LIM_LOOSE = 6,
  parameter int F_LIM_TIGHT = 3,
  parameter int M_WIN       = 4,
  parameter int M_LIM       = 3,
  localparam int BIT_W = $clog2(BLOCK_BITS),
  localparam int BLK_W = $clog2(BLOCKS),
  localparam int SUB_W = $clog2(SUBS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_i,
  input  logic             bit_en_i,
  input  logic             f_tight_i,
  input  logic             m_oof_en_i,
  input  logic             par_req_i,
  output logic             oof_o,
  output logic             frame_start_o,
  output logic [SUB_W-1:0] sub_o,
  output logic [BLK_W-1:0] blk_o,
  output logic             ovh_o
);

  localparam int FG_W = $clog2(FSYNC_LEN + 1);
  localparam int FC_W = $clog2(F_WIN + 1);
  localparam int MC_W = $clog2(M_WIN + 1);

  fa_state_t        st_q;
  logic [BIT_W-1:0] bitc_q;
  logic [BLK_W-1:0] blk_q;
  logic [SUB_W-1:0] sub_q;
  logic [FG_W-1:0]  fgood_q;
  logic [1:0]       m_hist_q;
  logic [1:0]       pstage_q;
  logic             p1_ok_q;
  logic             merr_q;
  logic             prev_par;
  logic [FC_W-1:0]  f_cnt_if;
  logic [MC_W-1:0]  m_cnt_if;
  logic [FC_W-1:0]  f_lim;

  // Position decode of the presented bit.
  logic is_ovh, first_slot, f_slot, m_slot, m_last, p1_slot, p2_slot, frame0;
  logic f_mis, m_mis, m_frame_err;

  assign is_ovh     = bitc_q == '0;
  assign first_slot = is_ovh && (blk_q == '0);
  assign f_slot     = is_ovh && blk_q[0];
  assign m_slot     = first_slot && (int'(sub_q) >= SUBS - 3);
  assign m_last     = first_slot && (int'(sub_q) == SUBS - 1);
  assign p1_slot    = first_slot && (int'(sub_q) == SUBS - 5);
  assign p2_slot    = first_slot && (int'(sub_q) == SUBS - 4);
  assign frame0     = first_slot && (sub_q == '0);
  assign f_mis      = f_slot && (bit_i != f_expect(int'(blk_q), BLOCKS));
  assign m_mis      = m_slot && (bit_i != m_expect(int'(sub_q), SUBS));
  assign m_frame_err = merr_q | m_mis;

  // Named events.
  logic slide_ev, adv, fsync_ev, relapse_ev, msync_ev, par_ok_ev, lock_ev;
  logic f_shift, m_shift, f_loss, m_loss;

  assign slide_ev   = (st_q == ST_FSRCH) && bit_en_i && f_mis;
  assign adv        = bit_en_i && !slide_ev;
  assign fsync_ev   = (st_q == ST_FSRCH) && bit_en_i && f_slot && !f_mis
                      && (fgood_q == FG_W'(FSYNC_LEN - 1));
  assign relapse_ev = ((st_q == ST_MSRCH) || (st_q == ST_PCHK)) && bit_en_i && f_mis;
  assign msync_ev   = (st_q == ST_MSRCH) && bit_en_i && first_slot
                      && ({m_hist_q, bit_i} == 3'b010);
  assign par_ok_ev  = (st_q == ST_PCHK) && bit_en_i && p2_slot && (pstage_q == 2'd2)
                      && p1_ok_q && (bit_i == prev_par);
  assign lock_ev    = (msync_ev && !par_req_i) || par_ok_ev;
  assign f_shift    = (st_q == ST_LOCK) && bit_en_i && f_slot;
  assign m_shift    = (st_q == ST_LOCK) && bit_en_i && m_last;
  assign f_lim      = f_tight_i ? FC_W'(F_LIM_TIGHT) : FC_W'(F_LIM_LOOSE);
  assign f_loss     = f_shift && (f_cnt_if >= f_lim);
  assign m_loss     = m_shift && m_oof_en_i && (m_cnt_if >= MC_W'(M_LIM));

  ds3fa_pos_counter #(
    .BLOCK_BITS(BLOCK_BITS), .BLOCKS(BLOCKS), .SUBS(SUBS)
  ) i_pos (
    .clk(clk), .rst_n(rst_n), .adv_i(adv), .load_sub_i(msync_ev),
    .sub_val_i(SUB_W'(SUBS - 1)),
    .bitc_o(bitc_q), .blk_o(blk_q), .sub_o(sub_q)
  );

  ds3fa_err_window #(.DEPTH(F_WIN)) i_fwin (
    .clk(clk), .rst_n(rst_n), .clr_i(lock_ev), .shift_i(f_shift),
    .err_i(f_mis), .cnt_if_o(f_cnt_if)
  );

  ds3fa_err_window #(.DEPTH(M_WIN)) i_mwin (
    .clk(clk), .rst_n(rst_n), .clr_i(lock_ev), .shift_i(m_shift),
    .err_i(m_frame_err), .cnt_if_o(m_cnt_if)
  );

  ds3fa_parity_acc i_par (
    .clk(clk), .rst_n(rst_n), .en_i(bit_en_i), .payload_i(!is_ovh),
    .frame0_i(frame0), .bit_i(bit_i), .prev_par_o(prev_par)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_FSRCH;
    end else begin
      unique case (st_q)
        ST_FSRCH: if (fsync_ev) st_q <= ST_MSRCH;
        ST_MSRCH: begin
          if (relapse_ev)    st_q <= ST_FSRCH;
          else if (msync_ev) st_q <= par_req_i ? ST_PCHK : ST_LOCK;
        end
        ST_PCHK: begin
          if (relapse_ev)     st_q <= ST_FSRCH;
          else if (par_ok_ev) st_q <= ST_LOCK;
        end
        ST_LOCK: if (f_loss || m_loss) st_q <= ST_FSRCH;
        default: st_q <= ST_FSRCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fgood_q  <= '0;
      m_hist_q <= 2'b11;
      pstage_q <= 2'd0;
      p1_ok_q  <= 1'b0;
      merr_q   <= 1'b0;
    end else begin
      if (st_q != ST_FSRCH) fgood_q <= '0;
      else if (bit_en_i && f_slot) fgood_q <= f_mis ? '0 : fgood_q + 1'b1;

      if (st_q != ST_MSRCH) m_hist_q <= 2'b11;
      else if (bit_en_i && first_slot) m_hist_q <= {m_hist_q[0], bit_i};

      if (st_q != ST_PCHK) pstage_q <= 2'd0;
      else if (bit_en_i && frame0 && pstage_q != 2'd2) pstage_q <= pstage_q + 2'd1;

      if (bit_en_i && p1_slot) p1_ok_q <= (bit_i == prev_par);

      if (st_q != ST_LOCK) merr_q <= 1'b0;
      else if (bit_en_i && m_slot) merr_q <= m_last ? 1'b0 : m_frame_err;
    end
  end

  assign oof_o         = st_q != ST_LOCK;
  assign frame_start_o = (st_q == ST_LOCK) && bit_en_i && frame0;
  assign sub_o         = sub_q;
  assign blk_o         = blk_q;
  assign ovh_o         = is_ovh;

  // R9
  gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en_i |=> ($stable({sub_q, blk_q, bitc_q}) && $stable(st_q)));

  // R2
  slide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slide_ev |=> $stable({sub_q, blk_q, bitc_q}));

  // R3
  lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oof_o) |-> $past(msync_ev || par_ok_ev));

  // R7
  nopar_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msync_ev && !par_req_i) |=> !oof_o);

  // R4
  oof_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oof_o) |-> $past(f_loss || m_loss));

endmodule

// File: tb/test_ds3_frame_align.sv
module test_ds3_frame_align;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0, bit_en = 1'b0, fsel = 1'b0, men = 1'b0, pen = 1'b0;
  logic oof, fs, ovh;
  logic [2:0] sub, blk;

  localparam int FRAME = 4760;

  always #5 clk = ~clk;

  ds3_frame_align i_ds3_frame_align (
    .clk(clk), .rst_n(rst_n), .bit_i(din), .bit_en_i(bit_en),
    .f_tight_i(fsel), .m_oof_en_i(men), .par_req_i(pen),
    .oof_o(oof), .frame_start_o(fs), .sub_o(sub), .blk_o(blk), .ovh_o(ovh)
  );

  int checks = 0, fails = 0;
  int gpos;
  int f_inj = 0;
  bit m_bad = 0, p_bad = 0;
  bit g_acc = 0, g_prev = 0;
  bit chk_on = 0;
  int pos_err = 0, fs_err = 0, fs_seen = 0;
  bit ever_lock = 0, ever_oof = 0;

  function automatic int e_sub(int p); return p / 680; endfunction
  function automatic int e_blk(int p); return (p % 680) / 85; endfunction
  function automatic bit e_ovh(int p); return (p % 85) == 0; endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // Generator: builds each bit of a well formed stream plus injected errors.
  task automatic send_bit();
    bit b;
    int s, k, q;
    s = e_sub(gpos); k = e_blk(gpos); q = gpos % 85;
    if (gpos == 0) begin g_prev = g_acc; g_acc = 0; end
    if (q != 0) b = 1'($urandom % 2);
    else if (k % 2 == 1) begin
      b = (k == 1) || (k == 7);
      if (f_inj > 0) begin b = !b; f_inj--; end
    end
    else if (k != 0) b = 1'($urandom % 2);
    else if (s < 2)  b = 1'b1;
    else if (s < 4)  b = g_prev ^ p_bad;
    else             b = (s == 5) ^ (m_bad && s == 4);
    if (q != 0) g_acc ^= b;
    @(negedge clk);
    din = b; bit_en = 1'b1;
    #1;
    if (chk_on) begin
      if (sub !== 3'(s) || blk !== 3'(k) || ovh !== (q == 0)) pos_err++;
      if (fs !== (gpos == 0 && !oof)) fs_err++;
      if (fs) fs_seen++;
    end
    if (!oof) ever_lock = 1; else ever_oof = 1;
    gpos = (gpos + 1) % FRAME;
  endtask

  task automatic send_gap();
    @(negedge clk);
    bit_en = 1'b0; din = 1'($urandom % 2);
    #1;
    if (sub !== 3'(e_sub(gpos)) || blk !== 3'(e_blk(gpos)) || ovh !== e_ovh(gpos)) pos_err++;
    if (fs !== 1'b0) fs_err++;
  endtask

  task automatic send_bits(input int n);
    for (int i = 0; i < n; i++) send_bit();
  endtask

  task automatic wait_lock(input int maxb);
    int n;
    n = 0;
    while (oof && n < maxb) begin send_bit(); n++; end
    send_bits(2);
  endtask

  task automatic align_frame();
    while (gpos != 0) send_bit();
  endtask

  task automatic send_frame(input bit mb);
    m_bad = mb;
    send_bits(FRAME);
    m_bad = 0;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    gpos = FRAME - (1 + int'($urandom % 6));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(oof === 1'b1, "R1", "oof after reset", oof, 1);
    check(fs === 1'b0, "R1", "frame_start after reset", fs, 0);

    // R2 R3 acquisition from an offset start
    wait_lock(30000);
    check(oof === 1'b0, "R2/R3", "acquired", oof, 0);

    // R8 position and frame-start over one full M-frame
    pos_err = 0; fs_err = 0; fs_seen = 0; chk_on = 1;
    send_bits(FRAME);
    chk_on = 0;
    check(pos_err == 0 && fs_err == 0, "R8", "position/frame_start mismatches", pos_err + fs_err, 0);
    check(fs_seen == 1, "R8", "frame_start pulses per frame", fs_seen, 1);

    // R9 strobe gaps freeze the block
    pos_err = 0; fs_err = 0; chk_on = 1;
    for (int i = 0; i < 300; i++) begin
      send_bit();
      if ($urandom % 3 == 0) send_gap();
    end
    chk_on = 0;
    check(pos_err == 0 && fs_err == 0, "R9", "mismatches with gaps", pos_err + fs_err, 0);
    check(oof === 1'b0, "R9", "lock kept across gaps", oof, 0);

    // R4 six of sixteen
    fsel = 0; ever_oof = 0;
    f_inj = 5; send_bits(1200);
    check(ever_oof == 0, "R4", "5 F errors keep frame", ever_oof, 0);
    send_bits(2800);
    f_inj = 6; send_bits(1300);
    check(oof === 1'b1, "R4", "6 F errors declare OOF", oof, 1);
    wait_lock(15000);
    check(oof === 1'b0, "R4", "relock after F errors", oof, 0);

    // R5 three of sixteen
    fsel = 1; ever_oof = 0;
    f_inj = 2; send_bits(700);
    check(ever_oof == 0, "R5", "2 F errors keep frame", ever_oof, 0);
    send_bits(2800);
    f_inj = 3; send_bits(700);
    check(oof === 1'b1, "R5", "3 F errors declare OOF", oof, 1);
    wait_lock(15000);

    // R6 M-bit criterion enabled; history cleared at lock (R10)
    men = 1; ever_oof = 0;
    align_frame();
    send_frame(1); send_frame(0); send_frame(1);
    check(ever_oof == 0, "R6", "2 of 4 M-frames in error", ever_oof, 0);
    send_frame(1);
    check(oof === 1'b1, "R6", "3 of 4 M-frames in error", oof, 1);
    wait_lock(15000);
    check(oof === 1'b0, "R10", "relock with cleared history", oof, 0);

    // R6 M-bit criterion disabled
    men = 0; ever_oof = 0;
    align_frame();
    send_frame(1); send_frame(1); send_frame(1);
    check(ever_oof == 0, "R6", "M errors ignored when disabled", ever_oof, 0);

    // R7 parity required, P-bits wrong
    pen = 1; p_bad = 1; fsel = 1;
    f_inj = 3; send_bits(700);
    check(oof === 1'b1, "R7", "forced OOF", oof, 1);
    ever_lock = 0;
    send_bits(3 * FRAME);
    check(ever_lock == 0, "R7", "no lock with bad P-bits", ever_lock, 0);
    p_bad = 0;
    wait_lock(20000);
    check(oof === 1'b0, "R7", "lock once P-bits good", oof, 0);

    // R7 parity not required: bad P-bits do not block acquisition
    pen = 0; p_bad = 1;
    f_inj = 3; send_bits(700);
    wait_lock(15000);
    check(oof === 1'b0, "R7", "lock ignoring P-bits", oof, 0);
    pos_err = 0; fs_err = 0; chk_on = 1;
    send_bits(1000);
    chk_on = 0;
    check(pos_err == 0 && fs_err == 0, "R8", "final position mismatches", pos_err + fs_err, 0);

    summary();
    $finish;
  end

endmodule